// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Datapath

This block is the fixed-point arithmetic core of an audio processing engine. It multiplies a 20-bit signed sample by a 16-bit signed coefficient. The full 36-bit product is then loaded into, added to or subtracted from a 40-bit accumulator. The accumulator has 4 guard bits above the product width, so a long filter sum can pass beyond the 36-bit range and come back without losing precision.

On every accepted operation, the new accumulator value passes through an arithmetic scaler that shifts it left or right by 0 to 4 places. The result is then limited to a 24-bit audio word. That word is taken from bits 35..12 of the scaled value. When the scaled value does not fit, the word is clamped to full scale and a sticky overflow flag is raised. A sequencer drives one operation per valid cycle. The scaled and clamped word appears one clock later.

Top module: `mac_sat_core`

## Requirements
- R1: Operands are two's complement. With op code 2 (load) and `in_valid` high, the accumulator becomes the full 36-bit product `din*coef`, sign-extended to 40 bits.
- R2: With op code 3 (add), the sign-extended product is added to the accumulator.
- R3: With op code 4 (subtract), the sign-extended product is subtracted from the accumulator.
- R4: With op code 1 (clear), the accumulator becomes zero, and the output word that follows is 0.
- R5: While `in_valid` is low, the op code and operands are ignored. The accumulator and `out_word` keep their values. Op code 0 (hold) with `in_valid` high leaves the accumulator unchanged and re-scales it with the new shift settings.
- R6: Op codes 5, 6 and 7 behave exactly as hold.
- R7: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. `out_word` changes at that same edge.
- R8: With `in_valid` high, `shl` = 1 selects an arithmetic left shift by `shamt` and `shl` = 0 selects an arithmetic right shift (rounding toward minus infinity). A `shamt` above 4 acts as 4.
- R9: `out_word` is bits 35..12 of the shifted 40-bit value. If the shifted value is not representable in those 24 signed bits (some bit above 35 differs from bit 35), `out_word` is 0x7FFFFF for a positive value and 0x800000 for a negative value.
- R10: The accumulator holds 40 bits. A running sum that exceeds the 36-bit product range and later returns into it gives the exact result.
- R11: `ovf_flag` is set when an accepted operation clamps its output. It stays set until `flag_clr` is high. If a new clamp and `flag_clr` occur in the same cycle, the flag stays set.
- R12: Synchronous reset `rst` clears the accumulator, `out_word`, `out_valid` and `ovf_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operation on this edge |
| op | input | 3 | Operation code: 0 hold, 1 clear, 2 load, 3 add, 4 subtract |
| din | input | 20 | Signed data operand |
| coef | input | 16 | Signed coefficient |
| shl | input | 1 | 1 = shift left, 0 = shift right |
| shamt | input | 3 | Shift distance, limited to 4 |
| flag_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result of the previous accepted operation is on `out_word` |
| out_word | output | 24 | Scaled, saturated audio word |
| ovf_flag | output | 1 | Sticky saturation indicator |

## Verification
Every accepted operation exposes the accumulator through `out_word` on the very next edge. A wrong accumulator update is therefore visible one cycle after the faulty operation, provided the shift brings the affected bits into the 35..12 window. Errors in the guard bits stay hidden while the output is clamped. They appear only once the sum returns into range, so the bench first drives the sum 17 products deep and then brings it back. A faulty flag or clamp shows as a word that differs from full scale, or as a flag that fails to rise, fall or stick one edge after the operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DATA_W    = 20;
    localparam int COEF_W    = 16;
    localparam int PROD_W    = DATA_W + COEF_W;
    localparam int GUARD_W   = 4;
    localparam int ACC_W     = PROD_W + GUARD_W;
    localparam int OUT_W     = 24;
    localparam int OUT_LSB   = PROD_W - OUT_W;
    localparam int SHIFT_MAX = 4;
    localparam int SHAMT_W   = 3;
    localparam int EXT_W     = ACC_W + SHIFT_MAX;

    localparam logic [OUT_W-1:0] WORD_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] WORD_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_ADD   = 3'd3,
        OP_SUB   = 3'd4
    } mac_op_e;

    typedef struct packed {
        logic               left;
        logic [SHAMT_W-1:0] amt;
    } scale_t;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             clamped;
    } outw_t;

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int AW = DATA_W,
    parameter int BW = COEF_W,
    parameter int XW = ACC_W
) (
    input  logic signed [AW-1:0] a,
    input  logic signed [BW-1:0] b,
    output logic signed [XW-1:0] p_ext
);
    localparam int PW = AW + BW;

    logic signed [PW-1:0] prod;

    always_comb begin
        prod  = a * b;
        p_ext = {{(XW-PW){prod[PW-1]}}, prod};
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int XW = ACC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [2:0]           op,
    input  logic signed [XW-1:0] p_ext,
    output logic signed [XW-1:0] acc_next
);
    logic signed [XW-1:0] acc_q;

    always_comb begin
        acc_next = acc_q;
        if (en) begin
            case (op)
                OP_CLEAR: acc_next = '0;
                OP_LOAD:  acc_next = p_ext;
                OP_ADD:   acc_next = acc_q + p_ext;
                OP_SUB:   acc_next = acc_q - p_ext;
                default:  acc_next = acc_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_next;
    end
endmodule

// File: rtl/mac_outscale.sv
module mac_outscale
    import mac_pkg::*;
#(
    parameter int XW   = ACC_W,
    parameter int SMAX = SHIFT_MAX,
    parameter int OW   = OUT_W,
    parameter int LSB  = OUT_LSB
) (
    input  logic signed [XW-1:0] acc,
    input  scale_t               scale,
    output outw_t                res
);
    localparam int WW  = XW + SMAX;
    localparam int TOP = LSB + OW - 1;

    logic signed [WW-1:0]  wide;
    logic signed [WW-1:0]  shifted;
    logic [SHAMT_W-1:0]    eff;
    logic [WW-1:TOP]       upper;
    logic                  fits;

    always_comb begin
        eff     = (scale.amt > SHAMT_W'(SMAX)) ? SHAMT_W'(SMAX) : scale.amt;
        wide    = {{SMAX{acc[XW-1]}}, acc};
        shifted = scale.left ? (wide <<< eff) : (wide >>> eff);
        upper   = shifted[WW-1:TOP];
        fits    = (&upper) | ~(|upper);
        res.clamped = ~fits;
        if (fits)
            res.word = shifted[TOP:LSB];
        else if (shifted[WW-1])
            res.word = WORD_MIN;
        else
            res.word = WORD_MAX;
    end
endmodule

// File: rtl/mac_sat_core.sv
module mac_sat_core
    import mac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2:0]         op,
    input  logic [DATA_W-1:0]  din,
    input  logic [COEF_W-1:0]  coef,
    input  logic               shl,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               flag_clr,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_word,
    output logic               ovf_flag
);
    logic signed [ACC_W-1:0] p_ext;
    logic signed [ACC_W-1:0] acc_next;
    scale_t                  scale;
    outw_t                   res;

    assign scale = '{left: shl, amt: shamt};

    mac_product #(.AW(DATA_W), .BW(COEF_W), .XW(ACC_W)) i_product (
        .a     (din),
        .b     (coef),
        .p_ext (p_ext)
    );

    mac_accum #(.XW(ACC_W)) i_accum (
        .clk      (clk),
        .rst      (rst),
        .en       (in_valid),
        .op       (op),
        .p_ext    (p_ext),
        .acc_next (acc_next)
    );

    mac_outscale #(.XW(ACC_W), .SMAX(SHIFT_MAX), .OW(OUT_W), .LSB(OUT_LSB)) i_outscale (
        .acc   (acc_next),
        .scale (scale),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            ovf_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_word <= res.word;
            ovf_flag <= (ovf_flag & ~flag_clr) | (in_valid & res.clamped);
        end
    end
endmodule

// File: rtl/mac_sat_core_chk.sv
module mac_sat_core_chk
    import mac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [2:0]         op,
    input logic               flag_clr,
    input logic               out_valid,
    input logic [OUT_W-1:0]   out_word,
    input logic               ovf_flag
);
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r5_idle_holds_word: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_CLEAR) |=> (out_word == '0));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    a_r11_flag_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !in_valid) |=> !ovf_flag);

    a_r9_rise_is_clamp: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (out_word == WORD_MAX || out_word == WORD_MIN));
endmodule

bind mac_sat_core mac_sat_core_chk i_chk (.*);

// File: tb/test_mac_sat_core.sv
module test_mac_sat_core;
    import mac_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [2:0]         op;
        logic [DATA_W-1:0]  d;
        logic [COEF_W-1:0]  c;
        logic               shl;
        logic [SHAMT_W-1:0] amt;
        logic [OUT_W-1:0]   exp;
        logic               fl;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{3'd2, 20'd1000,     16'd4096,  1'b0, 3'd0, 24'h0003E8, 1'b0}, // R1 load
        '{3'd3, 20'd2000,     16'd4096,  1'b0, 3'd0, 24'h000BB8, 1'b0}, // R2 add
        '{3'd4, 20'd500,      16'd8192,  1'b0, 3'd0, 24'h0007D0, 1'b0}, // R3 sub
        '{3'd0, 20'd0,        16'd0,     1'b1, 3'd2, 24'h001F40, 1'b0}, // R8 left 2
        '{3'd0, 20'd0,        16'd0,     1'b0, 3'd3, 24'h0000FA, 1'b0}, // R8 right 3
        '{3'd6, 20'd7,        16'd7,     1'b0, 3'd0, 24'h0007D0, 1'b0}, // R6 illegal
        '{3'd1, 20'd9,        16'd9,     1'b0, 3'd0, 24'h000000, 1'b0}, // R4 clear
        '{3'd2, 20'hFFFFD,    16'hF000,  1'b0, 3'd0, 24'h000003, 1'b0}, // R1 neg*neg
        '{3'd2, 20'hFFFFB,    16'd4096,  1'b0, 3'd0, 24'hFFFFFB, 1'b0}, // R1 neg*pos
        '{3'd0, 20'd0,        16'd0,     1'b0, 3'd7, 24'hFFFFFF, 1'b0}, // R8 limit 4
        '{3'd2, 20'h7FFFF,    16'h7FFF,  1'b0, 3'd0, 24'h3FFF78, 1'b0}, // R1 max
        '{3'd0, 20'd0,        16'd0,     1'b1, 3'd1, 24'h7FFEF0, 1'b0}, // R9 just fits
        '{3'd0, 20'd0,        16'd0,     1'b1, 3'd2, 24'h7FFFFF, 1'b1}, // R9 clamp
        '{3'd0, 20'd0,        16'd0,     1'b0, 3'd0, 24'h3FFF78, 1'b1}  // R11 sticky
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic [2:0]         op;
    logic [DATA_W-1:0]  din;
    logic [COEF_W-1:0]  coef;
    logic               shl;
    logic [SHAMT_W-1:0] shamt;
    logic               flag_clr;
    logic               out_valid;
    logic [OUT_W-1:0]   out_word;
    logic               ovf_flag;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_sat_core i_mac_sat_core (
        .clk, .rst, .in_valid, .op, .din, .coef, .shl, .shamt,
        .flag_clr, .out_valid, .out_word, .ovf_flag
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] o, input logic [DATA_W-1:0] d,
                         input logic [COEF_W-1:0] c, input logic l, input logic [SHAMT_W-1:0] a,
                         input logic fc);
        in_valid = v; op = o; din = d; coef = c; shl = l; shamt = a; flag_clr = fc;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 3'd0; din = '0; coef = '0;
        shl = 1'b0; shamt = '0; flag_clr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R12 reset word", 32'(out_word), 32'h0);
        chk("R12 reset valid", 32'(out_valid), 32'h0);
        chk("R12 reset flag", 32'(ovf_flag), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VEC[i].op, VEC[i].d, VEC[i].c, VEC[i].shl, VEC[i].amt, 1'b0);
            chk($sformatf("table %0d word", i), 32'(out_word), 32'(VEC[i].exp));
            chk($sformatf("table %0d flag", i), 32'(ovf_flag), 32'(VEC[i].fl));
            chk("R7 valid after accept", 32'(out_valid), 32'h1);
        end

        // Idle cycle with a load presented: ignored; flag cleared
        drive(1'b0, 3'd2, 20'd5, 16'd5, 1'b1, 3'd4, 1'b1);
        chk("R7 idle valid low", 32'(out_valid), 32'h0);
        chk("R5 idle word held", 32'(out_word), 32'h3FFF78);
        chk("R11 flag cleared", 32'(ovf_flag), 32'h0);
        drive(1'b1, 3'd0, 20'd5, 16'd5, 1'b0, 3'd0, 1'b0);
        chk("R5 accumulator untouched", 32'(out_word), 32'h3FFF78);

        drive(1'b1, 3'd7, 20'd123, 16'd77, 1'b0, 3'd0, 1'b0);
        chk("R6 op 7 is hold", 32'(out_word), 32'h3FFF78);

        // Guard bits: 16 more max products, then remove them
        for (int k = 0; k < 16; k++)
            drive(1'b1, 3'd3, 20'h7FFFF, 16'h7FFF, 1'b0, 3'd0, 1'b0);
        chk("R9 large sum clamps", 32'(out_word), 32'h7FFFFF);
        chk("R11 flag on large sum", 32'(ovf_flag), 32'h1);
        for (int k = 0; k < 16; k++)
            drive(1'b1, 3'd4, 20'h7FFFF, 16'h7FFF, 1'b0, 3'd0, 1'b0);
        chk("R10 guard bits restore exact sum", 32'(out_word), 32'h3FFF78);

        drive(1'b1, 3'd1, 20'd0, 16'd0, 1'b0, 3'd0, 1'b1);
        chk("R4 clear", 32'(out_word), 32'h0);
        drive(1'b1, 3'd2, 20'd3, 16'd4096, 1'b0, 3'd0, 1'b0);
        chk("R1 load small", 32'(out_word), 32'h3);
        drive(1'b1, 3'd3, 20'd4, 16'd4096, 1'b0, 3'd0, 1'b0);
        chk("R2 add", 32'(out_word), 32'h7);
        drive(1'b1, 3'd4, 20'd10, 16'd4096, 1'b0, 3'd0, 1'b0);
        chk("R3 subtract to negative", 32'(out_word), 32'hFFFFFD);

        drive(1'b1, 3'd2, 20'h80000, 16'h7FFF, 1'b0, 3'd0, 1'b0);
        chk("R1 most negative data", 32'(out_word), 32'hC00080);
        drive(1'b1, 3'd0, 20'd0, 16'd0, 1'b1, 3'd1, 1'b0);
        chk("R8 negative left fits", 32'(out_word), 32'h800100);
        chk("R11 no flag when fits", 32'(ovf_flag), 32'h0);
        drive(1'b1, 3'd0, 20'd0, 16'd0, 1'b1, 3'd2, 1'b0);
        chk("R9 negative clamp", 32'(out_word), 32'h800000);
        chk("R11 flag on negative clamp", 32'(ovf_flag), 32'h1);
        drive(1'b1, 3'd0, 20'd0, 16'd0, 1'b1, 3'd2, 1'b1);
        chk("R11 new clamp beats clear", 32'(ovf_flag), 32'h1);
        drive(1'b1, 3'd0, 20'd0, 16'd0, 1'b0, 3'd0, 1'b1);
        chk("R11 clear with in-range result", 32'(ovf_flag), 32'h0);
        chk("R8 shift zero", 32'(out_word), 32'hC00080);
        drive(1'b1, 3'd0, 20'd0, 16'd0, 1'b0, 3'd5, 1'b0);
        chk("R8 right amount limited to 4", 32'(out_word), 32'hFC0008);

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R12 mid-run reset word", 32'(out_word), 32'h0);
        drive(1'b1, 3'd0, 20'd0, 16'd0, 1'b0, 3'd0, 1'b0);
        chk("R12 accumulator cleared", 32'(out_word), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule